// File: doc/BRIEF.md
# Indexed performance counter bank

This block holds a small set of event counters that a processor core reaches through a word-addressed auxiliary register port. An index register picks one counter; a config register, two count registers and a snapshot pair then act on that counter only. Each counter is tied to one condition number. Condition inputs are single-cycle pulses from elsewhere in the core. Condition 0 is reserved as "never", so a counter is stopped by setting its condition to 0. There is no separate stop bit for each counter.

A shared control register holds the global enable, a self-clearing snapshot request, and a 16-bit upper field that software preserves across read-modify-write updates. A snapshot copies the whole selected counter into two 32-bit registers in one clock. Software can then read the two halves in any order without a carry tearing the value. Two read-only build registers let software discover the counter count, the counter width (32 + 16*s bits) and the number of conditions. An 8-character name for each condition is read through a condition index and two name words.

The register port always accepts an access. It has no back-pressure and no wait states. A write takes effect at the clock edge where the write strobe is sampled. Read data appears on the cycle after the read strobe and holds until the next read.

Top module: `perf_ctr_bank`

## Requirements
- R1: After reset, every counter, every config and the control register are zero, and reads of those registers return 0.
- R2: The index register (address 1, 8 bits, reads back) selects the counter that the config (2), count-low (3), count-high (4) and snapshot accesses act on.
- R3: A counter advances by exactly one on each clock edge where control bit 0 is set and the input of its configured condition is high. Condition k for k >= 1 is `cond_i[k]`.
- R4: Condition 0 never advances a counter. A config write whose value is at or above the condition count stores 0.
- R5: While control bit 0 is clear, no counter advances, whatever the condition inputs do.
- R6: The control register (address 0) holds the enable in bit 0 and the snapshot request in bit 1. Bits 31:16 store whatever is written and read back unchanged.
- R7: Writing the control register with bit 1 set copies the selected counter's value at that edge into snapshot-low (5) and snapshot-high (6). These hold their value while the counter keeps moving, until the next capture.
- R8: The snapshot bit clears itself one cycle after it is set, so later reads show bit 1 as 0.
- R9: Writes to count-low and count-high preset the selected counter. Count-high holds bits W-1:32 of the counter, and reads of both return the live value, zero-extended.
- R10: A counter wraps modulo 2^W, where W = 32 + 16*s.
- R11: Build register (address 7) reads {bit31 = 1, bits 9:8 = s, bits 7:0 = counter count}. Condition build (address 8) reads {bit31 = 1, bits 7:0 = condition count}.
- R12: The condition index (address 9) selects a name. Name word 0 (address 10) holds the ASCII bytes 'E','V','N','T' with the first character in bits 7:0. Name word 1 (address 11) holds '#', the upper hex digit, the lower hex digit and NUL, in that byte order (uppercase hex). An index at or above the condition count reads both words as 0.
- R13: With the counter index at or above the counter count, config and count reads return 0, config and count writes change no counter, and a snapshot captures 0.
- R14: Read data changes only on the edge that samples a read strobe, and then holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Word address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| cond_i | input | NUM_COND-1 | Condition pulses, bits NUM_COND-1 down to 1 |

## Verification
The bench builds the bank with three counters, s = 1 (48-bit counters) and six conditions. With three counters, index 3 is reachable yet has no counter behind it, which exercises the out-of-range paths. The 48-bit width has a partial high half, so the high-word preset, the zero-extended high read and the wrap from all-ones back to zero all take part. Six conditions in a 3-bit config field leave codes 6 and 7 unused, so a config write above the condition count hits the clamp to "never", and the name index can step one past the last condition.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  // Register word addresses of the auxiliary port
  typedef enum logic [3:0] {
    A_CTRL      = 4'd0,
    A_INDEX     = 4'd1,
    A_CFG       = 4'd2,
    A_CNTLO     = 4'd3,
    A_CNTHI     = 4'd4,
    A_SNAPLO    = 4'd5,
    A_SNAPHI    = 4'd6,
    A_BUILD     = 4'd7,
    A_CONDBUILD = 4'd8,
    A_CIDX      = 4'd9,
    A_NAME0     = 4'd10,
    A_NAME1     = 4'd11
  } reg_addr_e;

  // Control register bit positions
  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_SNAP_BIT = 1;

  // One ASCII hex digit, uppercase
  function automatic logic [7:0] hex_char(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
  endfunction

  // Eight-character name of a condition: {word1, word0}
  function automatic logic [63:0] cond_name(input logic [7:0] c);
    logic [31:0] w0;
    logic [31:0] w1;
    w0 = {8'h54, 8'h4E, 8'h56, 8'h45};                         // "EVNT"
    w1 = {8'h00, hex_char(c[3:0]), hex_char(c[7:4]), 8'h23};  // "#hl\0"
    return {w1, w0};
  endfunction

endpackage

// File: rtl/pcb_counter.sv
module pcb_counter #(
  parameter int unsigned W        = 48,
  parameter int unsigned NUM_COND = 16,
  parameter int unsigned CFGW     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic [NUM_COND-1:0] cond_vec_i,
  input  logic                cfg_we_i,
  input  logic [CFGW-1:0]     cfg_wval_i,
  input  logic                lo_we_i,
  input  logic                hi_we_i,
  input  logic [31:0]         wdata_i,
  output logic [CFGW-1:0]     cfg_o,
  output logic [W-1:0]        cnt_o
);
  localparam int unsigned CSPAN = 1 << CFGW;

  logic [CFGW-1:0]  cfg_q;
  logic [W-1:0]     cnt_q;
  logic [W-1:0]     cnt_nxt;
  logic [CSPAN-1:0] cond_pad;
  logic             hit;
  logic [63:0]      hi_ext;
  logic [W-1:0]     lo_val;

  // Pad so every storable config value indexes a defined bit
  assign cond_pad = CSPAN'(cond_vec_i);
  assign hit      = en_i & cond_pad[cfg_q];

  // High preset: upper bits from write data, low 32 bits kept
  assign hi_ext = {wdata_i, cnt_q[31:0]};

  always_comb begin
    lo_val        = cnt_q;
    lo_val[31:0]  = wdata_i;
    cnt_nxt       = cnt_q;
    if (hit)      cnt_nxt = cnt_q + W'(1);
    if (lo_we_i)  cnt_nxt = lo_val;
    if (hi_we_i)  cnt_nxt = hi_ext[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt_q <= '0;
    end else begin
      if (cfg_we_i) cfg_q <= cfg_wval_i;
      cnt_q <= cnt_nxt;
    end
  end

  assign cfg_o = cfg_q;
  assign cnt_o = cnt_q;

  // R4: condition 0 leaves the count alone
  a_r4_never_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q == '0 && !lo_we_i && !hi_we_i) |=> (cnt_q == $past(cnt_q)));

  // R5: global enable low freezes the count
  a_r5_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !lo_we_i && !hi_we_i) |=> (cnt_q == $past(cnt_q)));

  // R3: a counter never moves by more than one per clock
  a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_we_i && !hi_we_i) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + W'(1)));

endmodule

// File: rtl/pcb_snapshot.sv
module pcb_snapshot #(
  parameter int unsigned W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] snap_o
);
  logic [W-1:0] snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     snap_q <= '0;
    else if (cap_i) snap_q <= din_i;
  end

  assign snap_o = snap_q;

  // R7: the snapshot pair only changes on a capture
  a_r7_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> $stable(snap_q));

  // R7: a capture loads the presented value
  a_r7_snap_load: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> (snap_q == $past(din_i)));

endmodule

// File: rtl/pcb_cond_name.sv
module pcb_cond_name #(
  parameter int unsigned NUM_COND = 16
) (
  input  logic [7:0]  cidx_i,
  output logic [63:0] name_o
);
  localparam logic [7:0] NCOND8 = 8'(NUM_COND);

  always_comb begin
    if (cidx_i < NCOND8) name_o = pcb_pkg::cond_name(cidx_i);
    else                 name_o = '0;
  end

endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank #(
  parameter int unsigned NUM_CTR  = 4,   // 1..255
  parameter int unsigned SIZE_SEL = 1,   // 0..2, width 32 + 16*SIZE_SEL
  parameter int unsigned NUM_COND = 16   // 2..255, condition 0 is "never"
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [3:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_COND-1:1] cond_i
);
  import pcb_pkg::*;

  localparam int unsigned W      = 32 + 16 * SIZE_SEL;
  localparam int unsigned CFGW   = $clog2(NUM_COND);
  localparam logic [7:0]  NCTR8  = 8'(NUM_CTR);
  localparam logic [7:0]  NCOND8 = 8'(NUM_COND);
  localparam logic [1:0]  SIZE2  = 2'(SIZE_SEL);

  // Control and index state
  logic        en_q;
  logic        snap_bit_q;
  logic [15:0] keep_q;
  logic [7:0]  idx_q;
  logic [7:0]  cidx_q;

  logic wr_ctrl, wr_cfg, wr_lo, wr_hi;
  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_cfg  = reg_wr && (reg_addr == A_CFG);
  assign wr_lo   = reg_wr && (reg_addr == A_CNTLO);
  assign wr_hi   = reg_wr && (reg_addr == A_CNTHI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      snap_bit_q <= 1'b0;
      keep_q     <= '0;
      idx_q      <= '0;
      cidx_q     <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q       <= reg_wdata[CTRL_EN_BIT];
        snap_bit_q <= reg_wdata[CTRL_SNAP_BIT];
        keep_q     <= reg_wdata[31:16];
      end else begin
        snap_bit_q <= 1'b0;
      end
      if (reg_wr && reg_addr == A_INDEX) idx_q  <= reg_wdata[7:0];
      if (reg_wr && reg_addr == A_CIDX)  cidx_q <= reg_wdata[7:0];
    end
  end

  // Config values beyond the condition count fall back to "never"
  logic [CFGW-1:0] cfg_wval;
  assign cfg_wval = (reg_wdata < 32'(NUM_COND)) ? reg_wdata[CFGW-1:0] : '0;

  // Condition vector with bit 0 tied low: condition 0 never fires
  logic [NUM_COND-1:0] cond_vec;
  assign cond_vec = {cond_i, 1'b0};

  // Counter array
  logic [NUM_CTR-1:0][W-1:0]    cnt_arr;
  logic [NUM_CTR-1:0][CFGW-1:0] cfg_arr;

  for (genvar gi = 0; gi < NUM_CTR; gi++) begin : g_ctr
    logic sel;
    assign sel = (idx_q == 8'(gi));
    pcb_counter #(
      .W        (W),
      .NUM_COND (NUM_COND),
      .CFGW     (CFGW)
    ) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (en_q),
      .cond_vec_i (cond_vec),
      .cfg_we_i   (wr_cfg & sel),
      .cfg_wval_i (cfg_wval),
      .lo_we_i    (wr_lo & sel),
      .hi_we_i    (wr_hi & sel),
      .wdata_i    (reg_wdata),
      .cfg_o      (cfg_arr[gi]),
      .cnt_o      (cnt_arr[gi])
    );
  end

  // Selected counter; zero when the index has no counter behind it
  logic [W-1:0]    cnt_sel;
  logic [CFGW-1:0] cfg_sel;
  logic            sel_ok;

  assign sel_ok = (idx_q < NCTR8);

  always_comb begin
    cnt_sel = '0;
    cfg_sel = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (idx_q == 8'(i)) begin
        cnt_sel = cnt_arr[i];
        cfg_sel = cfg_arr[i];
      end
    end
  end

  // Snapshot pair
  logic         snap_cap;
  logic [W-1:0] snap_val;
  assign snap_cap = wr_ctrl & reg_wdata[CTRL_SNAP_BIT];

  pcb_snapshot #(.W(W)) u_snap (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_i  (snap_cap),
    .din_i  (cnt_sel),
    .snap_o (snap_val)
  );

  // Condition names
  logic [63:0] name_val;
  pcb_cond_name #(.NUM_COND(NUM_COND)) u_name (
    .cidx_i (cidx_q),
    .name_o (name_val)
  );

  // Read mux and registered read data
  logic [63:0] cnt64, snap64;
  logic [31:0] rd_val;
  assign cnt64  = 64'(cnt_sel);
  assign snap64 = 64'(snap_val);

  always_comb begin
    case (reg_addr)
      A_CTRL:      rd_val = {keep_q, 14'b0, snap_bit_q, en_q};
      A_INDEX:     rd_val = {24'b0, idx_q};
      A_CFG:       rd_val = 32'(cfg_sel);
      A_CNTLO:     rd_val = cnt64[31:0];
      A_CNTHI:     rd_val = cnt64[63:32];
      A_SNAPLO:    rd_val = snap64[31:0];
      A_SNAPHI:    rd_val = snap64[63:32];
      A_BUILD:     rd_val = {1'b1, 21'b0, SIZE2, NCTR8};
      A_CONDBUILD: rd_val = {1'b1, 23'b0, NCOND8};
      A_CIDX:      rd_val = {24'b0, cidx_q};
      A_NAME0:     rd_val = name_val[31:0];
      A_NAME1:     rd_val = name_val[63:32];
      default:     rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end

  // R8: the snapshot request never lingers
  a_r8_snap_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_bit_q && !wr_ctrl) |=> !snap_bit_q);

  // R14: read data holds between read strobes
  a_r14_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));

  // R13: an out-of-range index writes no config and no count
  a_r13_oob_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_cfg || wr_lo || wr_hi) && !sel_ok) |=> $stable(cfg_arr));

  // R13: a snapshot taken at an out-of-range index yields zero
  a_r13_oob_snap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_cap && !sel_ok) |=> (snap_val == '0));

endmodule

// File: tb/tb_perf_ctr_bank.sv
`timescale 1ns/1ps
module tb_perf_ctr_bank;
  localparam int unsigned NCTR = 3;
  localparam int unsigned SSEL = 1;
  localparam int unsigned NCND = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NCND-1:1] cond_i = '0;

  perf_ctr_bank #(.NUM_CTR(NCTR), .SIZE_SEL(SSEL), .NUM_COND(NCND)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cond_i(cond_i)
  );

  always #4 clk = ~clk;   // 125 MHz

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  // Hold a condition pattern for exactly n rising edges
  task automatic pulse(input logic [4:0] pat, input int n);
    @(negedge clk);
    cond_i = pat;
    repeat (n) @(negedge clk);
    cond_i = '0;
  endtask

  // Vector: {ctr[1:0], cfg[2:0], pattern[4:0] (bit k-1 = condition k), cycles[7:0], enable, expected[15:0]}
  localparam int VN = 7;
  localparam logic [34:0] VEC [VN] = '{
    {2'd0, 3'd1, 5'b00001, 8'd5,  1'b1, 16'd5},   // R3
    {2'd1, 3'd3, 5'b00100, 8'd7,  1'b1, 16'd7},   // R3
    {2'd2, 3'd5, 5'b10000, 8'd3,  1'b1, 16'd3},   // R3
    {2'd0, 3'd2, 5'b11101, 8'd4,  1'b1, 16'd0},   // R3 other conditions only
    {2'd1, 3'd0, 5'b11111, 8'd6,  1'b1, 16'd0},   // R4 never
    {2'd2, 3'd4, 5'b01000, 8'd9,  1'b0, 16'd0},   // R5 gate off
    {2'd0, 3'd4, 5'b11111, 8'd12, 1'b1, 16'd12}   // R3
  };

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d, d2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd0, d); chk("R1 ctrl", d, 32'h0);
    rd(4'd2, d); chk("R1 cfg", d, 32'h0);
    rd(4'd3, d); chk("R1 count", d, 32'h0);

    // Table of counting vectors
    for (int v = 0; v < VN; v++) begin
      logic [34:0] e;
      e = VEC[v];
      wr(4'd1, {30'd0, e[34:33]});
      wr(4'd2, {29'd0, e[32:30]});
      wr(4'd3, 32'h0);
      wr(4'd4, 32'h0);
      wr(4'd0, {31'd0, e[16]});
      pulse(e[29:25], int'(e[24:17]));
      wr(4'd0, 32'h2);                  // enable off, snapshot
      rd(4'd5, d);  chk($sformatf("R7 R3 vec%0d snaplo", v), d, {16'd0, e[15:0]});
      rd(4'd6, d);  chk($sformatf("R7 vec%0d snaphi", v), d, 32'h0);
    end

    // R2 index readback, R8 snapshot bit cleared
    rd(4'd1, d); chk("R2 index", d, 32'h0);
    rd(4'd0, d); chk("R8 snap bit clear", d, 32'h0);

    // R6 upper control bits preserved
    wr(4'd0, 32'hABCD_0000);
    rd(4'd0, d); chk("R6 ctrl upper", d, 32'hABCD_0000);
    wr(4'd0, 32'h0);

    // R4 config clamp
    wr(4'd1, 32'd1);
    wr(4'd2, 32'd9);
    rd(4'd2, d); chk("R4 clamp", d, 32'h0);
    wr(4'd2, 32'd5);
    rd(4'd2, d); chk("R4 max cond", d, 32'd5);

    // R9 preset high and live read
    wr(4'd4, 32'h0000_1234);
    rd(4'd4, d); chk("R9 hi preset", d, 32'h0000_1234);
    wr(4'd3, 32'h89AB_CDEF);
    rd(4'd3, d); chk("R9 lo preset", d, 32'h89AB_CDEF);

    // R10 wrap: 2^48-2 plus three counts gives 1
    wr(4'd2, 32'd1);
    wr(4'd3, 32'hFFFF_FFFE);
    wr(4'd4, 32'h0000_FFFF);
    wr(4'd0, 32'h1);
    pulse(5'b00001, 3);
    wr(4'd0, 32'h0);
    rd(4'd3, d); chk("R10 wrap lo", d, 32'h1);
    rd(4'd4, d); chk("R10 wrap hi", d, 32'h0);

    // R7 snapshot holds while counter moves (counter 0 holds 12, cfg 4)
    wr(4'd1, 32'd0);
    wr(4'd0, 32'h2);
    wr(4'd0, 32'h1);
    pulse(5'b01000, 3);
    wr(4'd0, 32'h0);
    rd(4'd5, d);  chk("R7 snap hold", d, 32'd12);
    rd(4'd3, d);  chk("R7 live count", d, 32'd15);
    wr(4'd0, 32'h2);
    rd(4'd5, d);  chk("R7 recapture", d, 32'd15);

    // R13 out-of-range index
    wr(4'd1, 32'd3);
    rd(4'd1, d); chk("R2 R13 index readback", d, 32'd3);
    wr(4'd2, 32'd2);
    wr(4'd3, 32'h5555);
    rd(4'd2, d); chk("R13 oob cfg", d, 32'h0);
    rd(4'd3, d); chk("R13 oob count", d, 32'h0);
    wr(4'd0, 32'h2);
    rd(4'd5, d); chk("R13 oob snap", d, 32'h0);
    wr(4'd1, 32'd2);
    rd(4'd2, d); chk("R13 ctr2 cfg kept", d, 32'd4);
    wr(4'd1, 32'd0);
    rd(4'd3, d); chk("R13 ctr0 count kept", d, 32'd15);

    // R11 discovery
    rd(4'd7, d); chk("R11 build", d, 32'h8000_0103);
    rd(4'd8, d); chk("R11 cond build", d, 32'h8000_0006);

    // R12 names
    wr(4'd9, 32'd3);
    rd(4'd10, d); chk("R12 name0", d, 32'h544E_5645);
    rd(4'd11, d); chk("R12 name1 c3", d, 32'h0033_3023);
    wr(4'd9, 32'd5);
    rd(4'd11, d); chk("R12 name1 c5", d, 32'h0035_3023);
    wr(4'd9, 32'd6);
    rd(4'd10, d); chk("R12 oob name0", d, 32'h0);
    rd(4'd11, d); chk("R12 oob name1", d, 32'h0);

    // R14 read data holds without a strobe
    rd(4'd7, d);
    repeat (4) @(negedge clk);
    d2 = reg_rdata;
    chk("R14 hold", d2, d);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule